// File: doc/BRIEF.md
# ATM Header Error Check Verifier and Cell Filter

This block sits behind cell delineation in an ATM receive path. It takes a byte stream of 53-byte cells, each marked with a start-of-cell flag. Cells are trusted only while an upstream sync-valid signal is high. For each cell the block checks the fifth header byte against a CRC-8 over the first four header bytes. A two-state machine decides whether a single-bit header error may be repaired: it rests in a correcting state and falls back to a detect-only state after any errored cell.

Every cell is then forwarded, repaired, dropped or replaced by a filler request, depending on per-link control bits. Errored cells that could not be repaired are counted in a saturating counter. When enabled, idle and unassigned cells are removed from the stream. The cell stream leaves five clock cycles after it enters. The header bytes of a cell must arrive on consecutive cycles; payload bytes may have gaps.

Top module: `hec_cell_filter`

## Requirements
- R1: After reset, outValid, outSoc and fillerReq are low, badHecCount is zero, and the machine is in the correcting state.
- R2: A cell is good when its fifth byte equals the CRC-8 (x^8+x^2+x+1, zero start, MSB first) of the first four header bytes, XORed with 0x55 when ctlCosetEn=1 and left plain when ctlCosetEn=0. A good cell is forwarded unchanged as 53 bytes, with outSoc on the first byte, each byte appearing five cycles after it was taken in. A good cell puts the machine in the correcting state.
- R3: In the correcting state with ctlCorrectEn=1, a header with exactly one flipped bit among its 40 bits (byte 0 bit 7 first, HEC byte last) is repaired, forwarded, and not counted. With ctlCorrectEn=0 it is treated as an unrepaired errored cell.
- R4: Any errored cell, repaired or not, leaves the machine in the detect-only state. In that state no repair is made and every errored cell is unrepaired. Only a good cell returns the machine to the correcting state.
- R5: Each unrepaired errored cell adds one to badHecCount. The count holds at 2^CNT_W-1 and does not wrap.
- R6: With ctlDiscardBad=1 and ctlImaMode=1, an unrepaired errored cell is not forwarded. Instead fillerReq pulses for one cycle, in the cycle its first byte would have appeared.
- R7: With ctlDiscardBad=1 and ctlImaMode=0, an unrepaired errored cell is dropped with no filler request. With ctlDiscardBad=0 it is forwarded unchanged, and it is still counted.
- R8: With ctlDropIdle=1, a cell that would otherwise be forwarded is dropped when its header is empty, judged after any repair. The 32-bit header has byte 0 in bits 31..24. It is empty when it equals 0x00000001 (idle), or when bits 27..4 and bit 0 are all zero (unassigned). A dropped empty cell raises no filler request. With ctlDropIdle=0 such cells are forwarded.
- R9: While syncValid is low, no input byte is taken, bytes still in the delay path are discarded, and the machine returns to the correcting state.
- R10: A cell begins only on a byte with inSoc high. Valid bytes that arrive while no cell is open and inSoc is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncValid | input | 1 | Delineation is locked; cells are trusted |
| inValid | input | 1 | inData carries a cell byte |
| inSoc | input | 1 | Marks the first byte of a cell |
| inData | input | 8 | Incoming cell byte |
| ctlCorrectEn | input | 1 | Permit single-bit header repair |
| ctlDiscardBad | input | 1 | Remove unrepaired errored cells |
| ctlImaMode | input | 1 | 1: removed errored cells request a filler; 0: plain drop |
| ctlDropIdle | input | 1 | Remove idle and unassigned cells |
| ctlCosetEn | input | 1 | Apply the 0x55 coset in the HEC comparison |
| outValid | output | 1 | outData carries a forwarded byte |
| outSoc | output | 1 | First byte of a forwarded cell |
| outData | output | 8 | Forwarded cell byte |
| fillerReq | output | 1 | One-cycle request to insert a filler cell |
| badHecCount | output | CNT_W | Saturating count of unrepaired errored cells |

## Verification
The bench aims at the state-machine edge: a second single-bit error right after a repair must be counted and passed raw, and a design that repaired in both states would report a count of zero there. It flips every header position, the HEC byte included, so a wrong signature table or byte-to-bit mapping shows up as a mangled or dropped cell. Dropping sync part-way through a header, followed by orphan bytes with no start marker, catches a design that completes stale cells or forgets to return to the correcting state. A long run of bad cells against a narrow counter shows whether the counter wraps instead of holding.

// File: rtl/hecf_pkg.sv
package hecf_pkg;

  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 5;
  localparam int HDR_BITS  = HDR_BYTES * BYTE_W;
  localparam int WORD_BITS = HDR_BITS - BYTE_W;

  typedef enum logic {
    ST_CORRECT = 1'b0,
    ST_DETECT  = 1'b1
  } hecState_e;

  // control -> datapath, valid in the cycle the HEC byte is taken in
  typedef struct packed {
    logic load;
    logic keep;
    logic fix;
    logic filler;
  } hecfStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hdrDone;
    logic synZero;
    logic synSingle;
    logic emptyRaw;
    logic emptyFixed;
  } hecfStatus_t;

  function automatic logic [7:0] crc8Msb(input logic [WORD_BITS-1:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = WORD_BITS - 1; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // syndrome produced by a single flip at header bit p (bit 0 = HEC lsb)
  function automatic logic [7:0] flipSignature(input int p);
    logic [WORD_BITS-1:0] w;
    if (p < BYTE_W) return 8'(1 << p);
    w = '0;
    w[p - BYTE_W] = 1'b1;
    return crc8Msb(w);
  endfunction

  function automatic logic isEmptyHdr(input logic [WORD_BITS-1:0] w);
    return (w == 32'h0000_0001) || ((w[27:4] == '0) && !w[0]);
  endfunction

endpackage

// File: rtl/hecf_syndrome.sv
module hecf_syndrome
  import hecf_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic [WORD_BITS-1:0] hdrWord,
  input  logic [BYTE_W-1:0]    hecByte,
  input  logic                 cosetEn,
  output logic                 synZero,
  output logic                 synSingle,
  output logic [HDR_BITS-1:0]  flipMask
);

  logic [7:0] expectHec;
  logic [7:0] syndrome;

  assign expectHec = crc8Msb(hdrWord) ^ (cosetEn ? COSET : 8'h00);
  assign syndrome  = hecByte ^ expectHec;

  for (genvar p = 0; p < HDR_BITS; p++) begin : g_sig
    localparam logic [7:0] SIG = flipSignature(p);
    assign flipMask[p] = (syndrome == SIG);
  end

  assign synZero   = (syndrome == 8'h00);
  assign synSingle = |flipMask;

endmodule

// File: rtl/hecf_datapath.sv
module hecf_datapath
  import hecf_pkg::*;
#(
  parameter int         CELL_BYTES = 53,
  parameter logic [7:0] COSET      = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncValid,
  input  logic              inValid,
  input  logic              inSoc,
  input  logic [BYTE_W-1:0] inData,
  input  logic              cosetEn,
  input  hecfStrobe_t       strobe,
  output hecfStatus_t       status,
  output logic              outValid,
  output logic              outSoc,
  output logic [BYTE_W-1:0] outData,
  output logic              fillerReq
);

  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int LAT   = HDR_BYTES;

  // ---------------- input side: cell framing ----------------
  logic             cellOpen;
  logic [IDX_W-1:0] inIdx;
  logic [IDX_W-1:0] idxNow;
  logic             accept;

  assign accept = syncValid && inValid && (inSoc || cellOpen);
  assign idxNow = inSoc ? '0 : inIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellOpen <= 1'b0;
      inIdx    <= '0;
    end else if (!syncValid) begin
      cellOpen <= 1'b0;
      inIdx    <= '0;
    end else if (accept) begin
      if (idxNow == IDX_W'(CELL_BYTES - 1)) begin
        cellOpen <= 1'b0;
        inIdx    <= '0;
      end else begin
        cellOpen <= 1'b1;
        inIdx    <= idxNow + 1'b1;
      end
    end
  end

  // ---------------- header capture ----------------
  logic [HDR_BYTES-2:0][BYTE_W-1:0] hdrByte;
  logic [WORD_BITS-1:0]             hdrWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrByte <= '0;
    end else if (accept && (idxNow < IDX_W'(HDR_BYTES - 1))) begin
      hdrByte[(HDR_BYTES - 2) - int'(idxNow)] <= inData;
    end
  end

  assign hdrWord = hdrByte;

  logic [HDR_BITS-1:0] flipMask;
  logic                synZero;
  logic                synSingle;

  hecf_syndrome #(.COSET(COSET)) u_syndrome (
    .hdrWord  (hdrWord),
    .hecByte  (inData),
    .cosetEn  (cosetEn),
    .synZero  (synZero),
    .synSingle(synSingle),
    .flipMask (flipMask)
  );

  assign status.hdrDone    = accept && (idxNow == IDX_W'(HDR_BYTES - 1));
  assign status.synZero    = synZero;
  assign status.synSingle  = synSingle;
  assign status.emptyRaw   = isEmptyHdr(hdrWord);
  assign status.emptyFixed = isEmptyHdr(hdrWord ^ flipMask[HDR_BITS-1:BYTE_W]);

  // ---------------- per-cell decision hold ----------------
  logic                keepCell;
  logic                fixOn;
  logic                fillerCell;
  logic [HDR_BITS-1:0] fixMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepCell   <= 1'b0;
      fixOn      <= 1'b0;
      fillerCell <= 1'b0;
      fixMask    <= '0;
    end else if (strobe.load) begin
      keepCell   <= strobe.keep;
      fixOn      <= strobe.fix;
      fillerCell <= strobe.filler;
      fixMask    <= flipMask;
    end
  end

  // ---------------- fixed delay line ----------------
  logic [LAT-1:0]                 pValid;
  logic [LAT-1:0]                 pSoc;
  logic [LAT-1:0][BYTE_W-1:0]     pData;
  logic [LAT-1:0][IDX_W-1:0]      pIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pValid <= '0;
      pSoc   <= '0;
      pData  <= '0;
      pIdx   <= '0;
    end else begin
      pValid <= syncValid ? {pValid[LAT-2:0], accept} : '0;
      pSoc   <= {pSoc[LAT-2:0], accept && inSoc};
      pData  <= {pData[LAT-2:0], inData};
      pIdx   <= {pIdx[LAT-2:0], idxNow};
    end
  end

  logic              tailValid;
  logic              tailSoc;
  logic [BYTE_W-1:0] tailData;
  logic [IDX_W-1:0]  tailIdx;
  logic [BYTE_W-1:0] fixByte;

  assign tailValid = pValid[LAT-1];
  assign tailSoc   = pSoc[LAT-1];
  assign tailData  = pData[LAT-1];
  assign tailIdx   = pIdx[LAT-1];

  always_comb begin
    fixByte = '0;
    if (fixOn) begin
      for (int b = 0; b < HDR_BYTES; b++) begin
        if (tailIdx == IDX_W'(b)) fixByte = fixMask[(HDR_BYTES - 1 - b) * BYTE_W +: BYTE_W];
      end
    end
  end

  // ---------------- output stage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSoc    <= 1'b0;
      outData   <= '0;
      fillerReq <= 1'b0;
    end else begin
      outValid  <= syncValid && tailValid && keepCell;
      outSoc    <= syncValid && tailValid && tailSoc && keepCell;
      outData   <= tailData ^ fixByte;
      fillerReq <= syncValid && tailValid && tailSoc && fillerCell;
    end
  end

endmodule

// File: rtl/hecf_control.sv
module hecf_control
  import hecf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncValid,
  input  logic             ctlCorrectEn,
  input  logic             ctlDiscardBad,
  input  logic             ctlImaMode,
  input  logic             ctlDropIdle,
  input  hecfStatus_t      status,
  output hecfStrobe_t      strobe,
  output logic [CNT_W-1:0] badHecCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  hecState_e state;
  hecState_e stateNext;
  logic      errored;
  logic      canFix;
  logic      countIt;
  logic      emptyHdr;

  assign errored  = !status.synZero;
  assign canFix   = errored && (state == ST_CORRECT) && ctlCorrectEn && status.synSingle;
  assign countIt  = errored && !canFix;
  assign emptyHdr = canFix ? status.emptyFixed : status.emptyRaw;

  always_comb begin
    strobe.load   = status.hdrDone;
    strobe.fix    = canFix;
    strobe.keep   = (!countIt || !ctlDiscardBad) && !(ctlDropIdle && emptyHdr);
    strobe.filler = countIt && ctlDiscardBad && ctlImaMode;
  end

  always_comb begin
    stateNext = state;
    if (!syncValid)          stateNext = ST_CORRECT;
    else if (status.hdrDone) stateNext = errored ? ST_DETECT : ST_CORRECT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CORRECT;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badHecCount <= '0;
    end else if (status.hdrDone && countIt && (badHecCount != CNT_MAX)) begin
      badHecCount <= badHecCount + 1'b1;
    end
  end

endmodule

// File: rtl/hec_cell_filter.sv
module hec_cell_filter
  import hecf_pkg::*;
#(
  parameter int         CELL_BYTES = 53,
  parameter int         CNT_W      = 16,
  parameter logic [7:0] COSET      = 8'h55
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncValid,
  input  logic             inValid,
  input  logic             inSoc,
  input  logic [7:0]       inData,
  input  logic             ctlCorrectEn,
  input  logic             ctlDiscardBad,
  input  logic             ctlImaMode,
  input  logic             ctlDropIdle,
  input  logic             ctlCosetEn,
  output logic             outValid,
  output logic             outSoc,
  output logic [7:0]       outData,
  output logic             fillerReq,
  output logic [CNT_W-1:0] badHecCount
);

  hecfStrobe_t strobe;
  hecfStatus_t status;

  hecf_datapath #(.CELL_BYTES(CELL_BYTES), .COSET(COSET)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .syncValid(syncValid),
    .inValid  (inValid),
    .inSoc    (inSoc),
    .inData   (inData),
    .cosetEn  (ctlCosetEn),
    .strobe   (strobe),
    .status   (status),
    .outValid (outValid),
    .outSoc   (outSoc),
    .outData  (outData),
    .fillerReq(fillerReq)
  );

  hecf_control #(.CNT_W(CNT_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .syncValid    (syncValid),
    .ctlCorrectEn (ctlCorrectEn),
    .ctlDiscardBad(ctlDiscardBad),
    .ctlImaMode   (ctlImaMode),
    .ctlDropIdle  (ctlDropIdle),
    .status       (status),
    .strobe       (strobe),
    .badHecCount  (badHecCount)
  );

endmodule

// File: rtl/hecf_checker.sv
module hecf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncValid,
  input logic             inValid,
  input logic             outValid,
  input logic             outSoc,
  input logic             fillerReq,
  input logic [CNT_W-1:0] badHecCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1: reset leaves the outputs quiet and the count cleared
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outSoc && !fillerReq && (badHecCount == '0)));

  // R2: every forwarded byte was taken in six edges earlier under sync
  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && syncValid, 6));

  // R2: start marker only on a valid byte
  p_soc_with_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    outSoc |-> outValid);

  // R5: count moves by exactly one when it moves
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (badHecCount != $past(badHecCount)) |-> (badHecCount == $past(badHecCount) + 1'b1));

  // R5: count holds once saturated
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(badHecCount) == CNT_MAX) |-> (badHecCount == CNT_MAX));

  // R6: filler request is a single-cycle pulse and never coincides with data
  p_filler_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillerReq |=> !fillerReq);
  p_filler_no_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillerReq |-> !outValid);

  // R9: loss of sync stops the output stream
  p_sync_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    !syncValid |=> (!outValid && !fillerReq));

endmodule

bind hec_cell_filter hecf_checker #(.CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .syncValid  (syncValid),
  .inValid    (inValid),
  .outValid   (outValid),
  .outSoc     (outSoc),
  .fillerReq  (fillerReq),
  .badHecCount(badHecCount)
);

// File: tb/hec_cell_filter_tb.sv
module hec_cell_filter_tb;

  localparam int CELL    = 53;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncValid = 1'b0;
  logic inValid = 1'b0;
  logic inSoc = 1'b0;
  logic [7:0] inData = '0;
  logic ctlCorrectEn = 1'b1;
  logic ctlDiscardBad = 1'b0;
  logic ctlImaMode = 1'b0;
  logic ctlDropIdle = 1'b0;
  logic ctlCosetEn = 1'b1;
  logic outValid;
  logic outSoc;
  logic [7:0] outData;
  logic fillerReq;
  logic [CNT_W-1:0] badHecCount;

  always #4 clk = ~clk;

  hec_cell_filter #(.CELL_BYTES(CELL), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .syncValid(syncValid),
    .inValid(inValid), .inSoc(inSoc), .inData(inData),
    .ctlCorrectEn(ctlCorrectEn), .ctlDiscardBad(ctlDiscardBad),
    .ctlImaMode(ctlImaMode), .ctlDropIdle(ctlDropIdle), .ctlCosetEn(ctlCosetEn),
    .outValid(outValid), .outSoc(outSoc), .outData(outData),
    .fillerReq(fillerReq), .badHecCount(badHecCount)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [7:0] cellBuf [CELL];
  logic [7:0] expQ [$];
  logic [7:0] gotQ [$];
  int fillerSeen = 0;
  int socSeen = 0;
  bit socOnFirst = 0;
  int mState = 0;   // 0 correcting, 1 detect-only
  int mCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (outSoc && gotQ.size() == 0) socOnFirst = 1;
        if (outSoc) socSeen++;
        gotQ.push_back(outData);
      end
      if (fillerReq) fillerSeen++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    finishRun();
  end

  function automatic logic [7:0] tbCrc(input logic [31:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic top = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (top) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic bit hecOk(input logic [39:0] w);
    return w[7:0] == (tbCrc(w[39:8]) ^ (ctlCosetEn ? 8'h55 : 8'h00));
  endfunction

  function automatic bit emptyHdr(input logic [31:0] w);
    return (w == 32'h1) || (w[27:4] == 24'h0 && w[0] == 1'b0);
  endfunction

  task automatic makeCell(input logic [31:0] hdr, input logic [39:0] err);
    logic [39:0] hw;
    hw = {hdr, tbCrc(hdr) ^ (ctlCosetEn ? 8'h55 : 8'h00)} ^ err;
    for (int i = 0; i < 5; i++) cellBuf[i] = hw[39 - 8 * i -: 8];
    for (int i = 5; i < CELL; i++) cellBuf[i] = 8'($urandom);
  endtask

  task automatic pushByte(input logic [7:0] b, input bit soc);
    @(negedge clk);
    inValid = 1'b1;
    inSoc = soc;
    inData = b;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inSoc = 1'b0;
    end
  endtask

  task automatic sendCell(input bit gapOk);
    for (int i = 0; i < CELL; i++) begin
      if (gapOk && i >= 5 && ($urandom % 5) == 0) idleCycles(1 + $urandom % 2);
      pushByte(cellBuf[i], i == 0);
    end
    idleCycles(10);
  endtask

  task automatic modelCell(output string tag, output bit keep, output bit filler);
    logic [39:0] word, fixed, flip;
    bit good, single, canFix, countIt, empty;
    word = {cellBuf[0], cellBuf[1], cellBuf[2], cellBuf[3], cellBuf[4]};
    good = hecOk(word);
    single = 0;
    fixed = word;
    for (int p = 0; p < 40; p++) begin
      flip = word ^ (40'd1 << p);
      if (!good && !single && hecOk(flip)) begin
        single = 1;
        fixed = flip;
      end
    end
    canFix = !good && mState == 0 && ctlCorrectEn && single;
    countIt = !good && !canFix;
    empty = emptyHdr(canFix ? fixed[39:8] : word[39:8]);
    keep = (!countIt || !ctlDiscardBad) && !(ctlDropIdle && empty);
    filler = countIt && ctlDiscardBad && ctlImaMode;
    expQ.delete();
    if (keep) begin
      for (int i = 0; i < CELL; i++)
        expQ.push_back((i < 5 && canFix) ? fixed[39 - 8 * i -: 8] : cellBuf[i]);
    end
    mState = good ? 0 : 1;
    if (countIt && mCount < CNT_MAX) mCount++;
    if (good) tag = "R2";
    else if (canFix) tag = "R3";
    else if (countIt && ctlDiscardBad) tag = ctlImaMode ? "R6" : "R7";
    else if (mState == 1 && single) tag = "R4";
    else tag = "R7";
    if (ctlDropIdle && empty && !(countIt && ctlDiscardBad)) tag = "R8";
  endtask

  task automatic runCell(input string forceTag, input bit gapOk);
    string tag;
    bit keep, filler;
    int mism;
    gotQ.delete();
    fillerSeen = 0;
    socSeen = 0;
    socOnFirst = 0;
    modelCell(tag, keep, filler);
    if (forceTag != "") tag = forceTag;
    sendCell(gapOk);
    mism = 0;
    if (gotQ.size() == expQ.size())
      for (int i = 0; i < expQ.size(); i++) if (gotQ[i] !== expQ[i]) mism++;
    check(gotQ.size() == expQ.size() && mism == 0 && socSeen == (keep ? 1 : 0)
          && (!keep || socOnFirst), tag, "cell bytes (size)",
          gotQ.size(), expQ.size());
    check(badHecCount == CNT_W'(mCount), "R5", "bad HEC count", badHecCount, mCount);
    check(fillerSeen == (filler ? 1 : 0), filler ? "R6" : tag, "filler pulses",
          fillerSeen, filler);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && !outSoc && !fillerReq, "R1", "outputs quiet in reset",
          {outValid, outSoc, fillerReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(badHecCount == 0, "R1", "count zero after reset", badHecCount, 0);
    syncValid = 1'b1;
    idleCycles(3);

    // R2 good cell, then R1/R3 repair from the reset state
    makeCell(32'h0123_4560, 40'h0);                 runCell("R2", 0);
    makeCell(32'h0ABC_DE00, 40'h1 << 30);           runCell("R3", 1);
    // R4: second single-bit error in detect-only state is not repaired
    makeCell(32'h0ABC_DE00, 40'h1 << 20);           runCell("R4", 0);
    makeCell(32'h0222_3330, 40'h0);                 runCell("R4", 0);
    // R3: repair of a flip in the HEC byte itself and in the top header bit
    makeCell(32'h0444_5550, 40'h1 << 3);            runCell("R3", 0);
    makeCell(32'h0666_7770, 40'h0);                 runCell("R2", 0);
    makeCell(32'h0666_7770, 40'h1 << 39);           runCell("R3", 0);
    makeCell(32'h0666_7770, 40'h0);                 runCell("R2", 0);
    // R6: IMA mode discard -> filler request
    ctlDiscardBad = 1; ctlImaMode = 1;
    makeCell(32'h0111_2220, 40'h3 << 12);           runCell("R6", 1);
    makeCell(32'h0111_2220, 40'h0);                 runCell("R4", 0);
    // R7: UNI mode discard -> plain drop
    ctlImaMode = 0;
    makeCell(32'h0999_8880, 40'h5 << 16);           runCell("R7", 0);
    makeCell(32'h0999_8880, 40'h0);                 runCell("R2", 0);
    // R3: correction disabled -> single-bit error counted, forwarded raw
    ctlDiscardBad = 0; ctlCorrectEn = 0;
    makeCell(32'h0FED_CBA0, 40'h1 << 9);            runCell("R3", 0);
    ctlCorrectEn = 1;
    makeCell(32'h0FED_CBA0, 40'h0);                 runCell("R2", 0);
    // R2: coset switch
    ctlCosetEn = 0;
    makeCell(32'h0555_0000, 40'h0);                 runCell("R2", 0);
    ctlCosetEn = 1;
    makeCell(32'h0555_0000, 40'h0);
    ctlCosetEn = 0; ctlDiscardBad = 1;              runCell("R2", 0);
    ctlCosetEn = 1; ctlDiscardBad = 0;
    makeCell(32'h0555_0000, 40'h0);                 runCell("R2", 0);
    // R8: idle and unassigned cells
    ctlDropIdle = 1;
    makeCell(32'h0000_0001, 40'h0);                 runCell("R8", 0);
    makeCell(32'hA000_000E, 40'h0);                 runCell("R8", 0);
    makeCell(32'h0000_0010, 40'h0);                 runCell("R8", 0);
    makeCell(32'h0000_0003, 40'h1 << 9);            runCell("R8", 0);
    ctlDropIdle = 0;
    makeCell(32'h0000_0001, 40'h0);                 runCell("R8", 0);

    // R9/R10: sync loss mid-header, orphan bytes afterwards
    makeCell(32'h0777_0000, 40'h3 << 33);           runCell("R4", 0);
    makeCell(32'h0123_0000, 40'h0);
    for (int i = 0; i < 3; i++) pushByte(cellBuf[i], i == 0);
    gotQ.delete(); fillerSeen = 0;
    @(negedge clk); syncValid = 0; inValid = 0;
    for (int i = 0; i < 5; i++) pushByte(cellBuf[i], i == 0);
    @(negedge clk); syncValid = 1;
    for (int i = 5; i < CELL; i++) pushByte(cellBuf[i], 0);
    idleCycles(12);
    mState = 0;
    check(gotQ.size() == 0 && fillerSeen == 0, "R9", "bytes after sync loss",
          gotQ.size(), 0);
    check(badHecCount == CNT_W'(mCount), "R10", "count after orphan bytes",
          badHecCount, mCount);
    makeCell(32'h0321_0000, 40'h1 << 25);           runCell("R9", 0);

    // random traffic
    for (int n = 0; n < 220; n++) begin
      logic [31:0] hdr;
      logic [39:0] err;
      int sel, p1, p2;
      ctlCorrectEn = $urandom % 2; ctlDiscardBad = $urandom % 2;
      ctlImaMode = $urandom % 2;   ctlDropIdle = $urandom % 2;
      ctlCosetEn = ($urandom % 8) != 0;
      sel = $urandom % 8;
      if (sel == 0) hdr = 32'h1;
      else if (sel == 1) hdr = {4'($urandom), 24'h0, 3'($urandom), 1'b0};
      else hdr = $urandom;
      sel = $urandom % 10;
      err = '0;
      p1 = $urandom % 40;
      p2 = (p1 + 1 + $urandom % 39) % 40;
      if (sel >= 5) err[p1] = 1'b1;
      if (sel >= 8) err[p2] = 1'b1;
      makeCell(hdr, err);
      runCell("", 1);
    end

    // R5: saturation
    ctlCorrectEn = 0; ctlDiscardBad = 1; ctlImaMode = 0; ctlDropIdle = 0; ctlCosetEn = 1;
    for (int n = 0; n < CNT_MAX + 2; n++) begin
      makeCell(32'h0BAD_0000, 40'h3 << 10);
      runCell("R7", 0);
    end
    check(badHecCount == CNT_W'(CNT_MAX), "R5", "count saturated", badHecCount, CNT_MAX);

    finishRun();
  end

endmodule